// File: doc/BRIEF.md
# Word to Hex Character Streamer

This block takes a binary word offered on a valid/ready input handshake and turns it into a stream of upper-case hexadecimal ASCII characters, one per accepted transfer on a byte-wide valid/ready output. Each word always produces a fixed number of characters, which is the word width divided by four. Leading zero digits are always included, and the most significant digit is sent first. The final character of each word is marked with a last flag.

Internally the captured word sits in a single register. Every time a character is accepted, the register is rotated left by one nibble. The character on the output is formed from the low nibble of the word rotated once more. Because the rotations add up to a full turn, the register holds the original word again once the last character has been sent. A nibble of 0 to 9 becomes an ASCII digit by OR-ing it with 0x30. A nibble of 10 to 15 becomes 'A' to 'F' by adding decimal 55. Upstream logic offers a word and then consumes the characters at whatever rate it can.

Top module: `hexser_top`

## Requirements
- R1: A synchronous active-high reset clears the character counter, drives outValid and outLast low, and leaves inReady high.
- R2: inReady is high only while no word is being streamed. A word is captured at a clock edge where inValid and inReady are both high, and the first character is valid in the following cycle.
- R3: Each captured word yields exactly WORD_W/4 characters (eight by default), most significant nibble first, with leading zeros included.
- R4: A nibble value n from 0 to 9 is sent as the byte 0x30 OR n (ASCII '0' to '9').
- R5: A nibble value n from 10 to 15 is sent as n plus 55 (ASCII 'A' to 'F', 0x41 to 0x46).
- R6: While outValid is high and outReady is low, outChar and outValid hold their values. The stream advances only on a cycle where outValid and outReady are both high.
- R7: outLast is high only on the final character of a word. In the cycle after that character is accepted, outValid is low and inReady is high.
- R8: inValid is ignored while a word is being streamed: no new word is captured and the current character stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word offered |
| inWord | input | WORD_W | Binary word to convert |
| inReady | output | 1 | Block can accept a word |
| outValid | output | 1 | outChar holds a character |
| outChar | output | 8 | ASCII hex character |
| outLast | output | 1 | Marks the final character of a word |
| outReady | input | 1 | Consumer accepts the character |

## Verification
The bench builds the block with its default 32-bit word. With that width every word has eight characters and the counter wraps at its top value of seven. This makes the all-zero and all-ones words, words that mix every digit and letter, and the end-of-word handoff reachable in a few hundred cycles. Those cycles include output stalls that are held for several cycles, random consumer back-pressure, and input offers made while a word is still being streamed.

// File: rtl/hexser_pkg.sv
package hexser_pkg;

  // Strobes that the controller sends to the datapath.
  typedef struct packed {
    logic load;     // capture a fresh input word
    logic advance;  // one character accepted, step to the next nibble
  } hexStrobe_t;

endpackage

// File: rtl/hexser_dp.sv
module hexser_dp
  import hexser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NIB_W  = 4,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  hexStrobe_t        strobe,
  input  logic [WORD_W-1:0] inWord,
  output logic [CHAR_W-1:0] outChar
);

  localparam int DIGITS = WORD_W / NIB_W;
  localparam int STEP_W = $clog2(DIGITS + 1);
  localparam logic [WORD_W-1:0] NIB_MASK   = {{(WORD_W-NIB_W){1'b0}}, {NIB_W{1'b1}}};
  localparam logic [CHAR_W-1:0] DIGIT_BASE = CHAR_W'(8'h30);
  localparam logic [CHAR_W-1:0] LETTER_OFS = CHAR_W'(55);
  localparam logic [NIB_W-1:0]  FIRST_LTR  = NIB_W'(10);

  logic [WORD_W-1:0] heldWord;
  logic [WORD_W-1:0] rotWord;
  logic [WORD_W-1:0] maskedWord;
  logic [NIB_W-1:0]  nib;
  logic [CHAR_W-1:0] nibExt;

  // The next digit is the top nibble, which a left rotation brings to the bottom.
  always_comb begin
    rotWord    = {heldWord[WORD_W-NIB_W-1:0], heldWord[WORD_W-1 -: NIB_W]};
    maskedWord = rotWord & NIB_MASK;
    nib        = maskedWord[NIB_W-1:0];
    nibExt     = {{(CHAR_W-NIB_W){1'b0}}, nib};
    if (nib < FIRST_LTR) outChar = nibExt | DIGIT_BASE;
    else                 outChar = nibExt + LETTER_OFS;
  end

  always_ff @(posedge clk) begin
    if (rst)                 heldWord <= '0;
    else if (strobe.load)    heldWord <= inWord;
    else if (strobe.advance) heldWord <= rotWord;
  end

  // Shadow state that exists only for the restore check.
  logic [WORD_W-1:0] shadowWord;
  logic [STEP_W-1:0] stepCount;
  always_ff @(posedge clk) begin
    if (rst) begin
      shadowWord <= '0;
      stepCount  <= '0;
    end else if (strobe.load) begin
      shadowWord <= inWord;
      stepCount  <= '0;
    end else if (strobe.advance) begin
      stepCount  <= stepCount + STEP_W'(1);
    end
  end

  // R3: a full turn of rotations returns the captured word
  a_r3_word_restored: assert property (@(posedge clk) disable iff (rst)
    (stepCount == STEP_W'(DIGITS)) |-> (heldWord == shadowWord));

  // R4/R5: only hex digit characters can appear
  always_comb begin
    if (!rst) begin
      a_r4_r5_charset: assert ((outChar >= CHAR_W'(8'h30) && outChar <= CHAR_W'(8'h39)) ||
                               (outChar >= CHAR_W'(8'h41) && outChar <= CHAR_W'(8'h46)));
    end
  end

endmodule

// File: rtl/hexser_ctrl.sv
module hexser_ctrl
  import hexser_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       outLast,
  output hexStrobe_t strobe
);

  localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DIGITS - 1);

  logic             busy;
  logic [CNT_W-1:0] charCount;

  always_comb begin
    inReady        = !busy;
    outValid       = busy;
    outLast        = busy && (charCount == LAST_IDX);
    strobe.load    = inValid && !busy;
    strobe.advance = busy && outReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      charCount <= '0;
    end else if (strobe.load) begin
      busy      <= 1'b1;
      charCount <= '0;
    end else if (strobe.advance) begin
      if (charCount == LAST_IDX) begin
        busy      <= 1'b0;
        charCount <= '0;
      end else begin
        charCount <= charCount + CNT_W'(1);
      end
    end
  end

  // R2: a capture starts the stream at the first character
  a_r2_capture_starts: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (outValid && !inReady && charCount == '0));

  // R3: each accepted non-final character steps the count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !outLast) |=> (charCount == $past(charCount) + CNT_W'(1)));

  // R7: acceptance of the final character returns to idle
  a_r7_last_then_idle: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outLast) |=> (!outValid && inReady));

  // R8: the stream is not cut short by anything but the final acceptance
  a_r8_stream_continues: assert property (@(posedge clk) disable iff (rst)
    (outValid && !(outReady && outLast)) |=> outValid);

endmodule

// File: rtl/hexser_top.sv
module hexser_top
  import hexser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output logic              outValid,
  output logic [7:0]        outChar,
  output logic              outLast,
  input  logic              outReady
);

  localparam int NIB_W  = 4;
  localparam int DIGITS = WORD_W / NIB_W;

  hexStrobe_t strobe;

  hexser_ctrl #(.DIGITS(DIGITS)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .strobe   (strobe)
  );

  hexser_dp #(.WORD_W(WORD_W), .NIB_W(NIB_W), .CHAR_W(8)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inWord  (inWord),
    .outChar (outChar)
  );

  // R6: a stalled character stays put
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outChar) && $stable(outLast)));

endmodule

// File: tb/hexser_top_tb_top.sv
module hexser_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int DIGITS     = WORD_W / 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic [WORD_W-1:0] inWord = '0;
  logic              inReady;
  logic              outValid;
  logic [7:0]        outChar;
  logic              outLast;
  logic              outReady = 1'b0;

  int  checks = 0;
  int  errors = 0;
  int  charsSeen = 0;
  int  wordsSent = 0;
  bit  stallAll = 1'b0;
  bit  randMode = 1'b0;
  bit  finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0]  expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hexser_top #(.WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .outValid(outValid), .outChar(outChar),
    .outLast(outLast), .outReady(outReady)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expChar(input logic [3:0] n);
    if (n <= 4'd9) return 8'(48 + int'(n));
    return 8'(65 + int'(n) - 10);
  endfunction

  // Driver: queue expected characters, then perform the input handshake.
  task automatic sendWord(input logic [WORD_W-1:0] w);
    for (int i = 0; i < DIGITS; i++)
      expQ.push_back({(i == DIGITS-1), expChar(w[WORD_W-1-4*i -: 4])});
    @(posedge clk); #1;
    inValid = 1'b1;
    inWord  = w;
    do @(negedge clk); while (!inReady);
    @(posedge clk); #1;
    inValid = 1'b0;
    inWord  = {lfsr, lfsr};
    wordsSent++;
    @(negedge clk);
    check(outValid == 1'b1, "R2 first char after capture", 32'(outValid), 32'd1);
  endtask

  task automatic drain();
    do @(negedge clk); while (expQ.size() != 0 || outValid);
  endtask

  // Consumer back-pressure.
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = stallAll ? 1'b0 : (randMode ? (lfsr[0] | lfsr[3]) : 1'b1);
    end
  end

  // Monitor and scoreboard.
  initial begin
    bit pendIdle = 0;
    bit holdPend = 0;
    logic [7:0] holdChar = '0;
    logic [8:0] item;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (pendIdle) begin
        check(!outValid && inReady, "R7 idle after last", {outValid, inReady}, 32'b01);
        pendIdle = 0;
      end
      if (holdPend) begin
        check(outValid && outChar == holdChar, "R6 stalled char held", outChar, holdChar);
        holdPend = 0;
      end
      if (outValid && !outReady) begin
        holdPend = 1;
        holdChar = outChar;
      end
      if (outValid && outReady) begin
        charsSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected character", outChar, 32'd0);
        end else begin
          item = expQ.pop_front();
          if (item[7:0] <= 8'h39)
            check(outChar == item[7:0], "R4 digit char", outChar, item[7:0]);
          else
            check(outChar == item[7:0], "R5 letter char", outChar, item[7:0]);
          check(outLast == item[8], "R7 last marker", outLast, item[8]);
          if (outLast) pendIdle = 1;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    check(outLast == 1'b0, "R1 outLast after reset", outLast, 0);

    // Plain streaming, leading zeros and boundary nibbles.
    sendWord(32'h0000_0000); drain();
    sendWord(32'hFFFF_FFFF); drain();
    sendWord(32'h0123_4567); drain();
    sendWord(32'h89AB_CDEF); drain();
    sendWord(32'h0000_000A); drain();

    // Random back-pressure, back-to-back words.
    randMode = 1'b1;
    sendWord(32'h9A5F_E071);
    sendWord(32'hDEAD_0042);
    sendWord(32'h1F2E_3D4C);
    drain();
    randMode = 1'b0;

    // R8: offers during a stalled stream are ignored.
    stallAll = 1'b1;
    sendWord(32'h3C0F_FEE9);
    @(posedge clk); #1;
    inValid = 1'b1;
    inWord  = 32'h7777_7777;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!inReady, "R8 busy refuses input", inReady, 0);
    end
    @(posedge clk); #1;
    inValid  = 1'b0;
    stallAll = 1'b0;
    drain();
    check(charsSeen == wordsSent * DIGITS, "R8 no extra word", charsSeen, wordsSent * DIGITS);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0 && charsSeen == wordsSent * DIGITS,
          "R3 character count per word", charsSeen, wordsSent * DIGITS);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule